// File: doc/BRIEF.md
# Long-Mode Page Table Walker

This block translates a 64-bit virtual address into a physical address by fetching page-table entries from memory, one level at a time. A request carries the virtual address, the table root, a flag that selects four-level or five-level tables, a flag that turns on the no-execute bit, and the access type. The walker reads entries through a read port that allows one read in flight. It stops at the first leaf it finds. A leaf can be a 4 KB page at the last level, a 2 MB page one level above, or a 1 GB page two levels above.

Every entry is checked for the present bit and for reserved bits. The reserved bits depend on the level and on whether the entry is a leaf. The walker sets accessed and dirty bits with a 32-bit compare-and-swap port. When a swap on a table pointer fails, that entry is read again. When a swap on the leaf fails, the whole walk starts again from the top. The result is a single-cycle done pulse. It carries the physical address, the page size, a fault code, and a permission set built from all the levels. A separate checker makes the final allow-or-deny decision from that permission set.

Top module: `pw_walker`

## Requirements
- R1: The entry address at each level is the 4 KB-aligned table base plus 8 times a 9-bit index. The index comes from virtual-address bits 56:48 at level 5, 47:39 at level 4, 38:30 at level 3, 29:21 at level 2 and 20:12 at level 1. The read address is therefore always 8-byte aligned.
- R2: With `req_five`=0 the first read is the level-4 entry, based on the root. With `req_five`=1 the first read is the level-5 entry. A walk to a 4 KB page with no faults and no bit updates therefore makes 4 reads or 5 reads.
- R3: An entry with bit 0 (present) clear ends the walk with `done_fault`=1 (not present). No further read is made.
- R4: Bit 7 (page size) set in a level-5 or level-4 entry ends the walk with `done_fault`=2 (reserved).
- R5: Bit 7 set at level 3 gives a 1 GB leaf, and bit 7 set at level 2 gives a 2 MB leaf. The walk stops at that leaf. `done_size` is 0 for 4 KB, 1 for 2 MB and 2 for 1 GB.
- R6: The following entry bits are reserved at every level: bits 51:PHYS_BITS, and also bit 63 (no-execute) when `req_nxe`=0. If any of them is set, `done_fault` is 2.
- R7: In a 2 MB or 1 GB leaf, the address-field bits below the page size are reserved, except bit 12. For a 2 MB leaf these are bits 20:13. For a 1 GB leaf they are bits 29:13.
- R8: When a non-leaf entry has bit 5 (accessed) clear, the walker sets it with compare-and-swap. If the swap fails, the same entry is read again.
- R9: On the leaf, the walker sets bit 5. For a store (`req_acc`=1) it also sets bit 6 (dirty). A compare-and-swap is issued only when one of these bits is still clear. If the swap fails, the walk restarts from the top level.
- R10: For a load (`req_acc`=0) or a fetch (`req_acc`=2) to a leaf whose dirty bit is clear, the write bit of `done_perm` is 0.
- R11: The physical address is the leaf's bits 51:12 with the bits below the page size taken from the virtual address instead.
- R12: `done_perm` is {exec, user, write}. Write is the AND of bit 1 over the levels walked. User is the AND of bit 2. Exec is 1 only when no level had bit 63 set.
- R13: The read request and the swap request are never raised together, and a read request stays raised until it is accepted. `done` lasts one cycle. On a fault, `done_paddr` and `done_perm` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_vaddr | input | 64 | Virtual address to translate |
| req_root | input | 64 | Root table address |
| req_five | input | 1 | 1 selects five-level tables |
| req_nxe | input | 1 | 1 enables the no-execute bit |
| req_acc | input | 2 | Access type: 0 load, 1 store, 2 fetch |
| rd_valid | output | 1 | Entry read request |
| rd_ready | input | 1 | Read request accepted |
| rd_addr | output | 64 | Entry address to read |
| rsp_valid | input | 1 | Read data returned |
| rsp_data | input | 64 | Entry value |
| cas_valid | output | 1 | Compare-and-swap request |
| cas_ready | input | 1 | Swap request accepted |
| cas_addr | output | 64 | Entry address to swap |
| cas_old | output | 32 | Expected low word |
| cas_new | output | 32 | Replacement low word |
| cas_done | input | 1 | Swap result valid, one cycle after acceptance |
| cas_ok | input | 1 | Swap matched and was written |
| done | output | 1 | One-cycle completion pulse |
| done_paddr | output | 64 | Physical address |
| done_size | output | 2 | Page size code |
| done_fault | output | 2 | 0 none, 1 not present, 2 reserved |
| done_perm | output | 3 | {exec, user, write} |

## Verification
The walker is driven with five kinds of table shapes:
- Complete four-level walks and complete five-level walks. Their read counts and address offsets show whether the start level is right.
- Walks that stop at a 2 MB leaf or a 1 GB leaf. These show whether the early stop and the address merge are right.
- Tables with a single corrupted entry. A cleared present bit, a page-size bit at an upper level, a high physical bit, a no-execute bit with no-execute off, and low bits in a large leaf each give their own fault code, and each stops the walk at its own read count.
- Tables with clear accessed and dirty bits. These show which entries get swapped and how the write permission is held back.
- Runs where the memory model fails one swap. The extra reads show whether the walker re-reads a single entry or restarts the whole walk.

// File: rtl/pw_pkg.sv
package pw_pkg;
    localparam int IDX_W  = 9;
    localparam int LVL_W  = 3;
    localparam int PG_SH  = 12;
    localparam int B_P    = 0;
    localparam int B_RW   = 1;
    localparam int B_US   = 2;
    localparam int B_A    = 5;
    localparam int B_D    = 6;
    localparam int B_PS   = 7;
    localparam int B_NX   = 63;
    localparam logic [63:0] ADDR_MASK = 64'h000F_FFFF_FFFF_F000;
    localparam logic [63:0] LOW_2M    = 64'h0000_0000_001F_FFFF;
    localparam logic [63:0] LOW_1G    = 64'h0000_0000_3FFF_FFFF;
    localparam logic [63:0] PAT_BIT   = 64'h0000_0000_0000_1000;

    typedef enum logic [1:0] {SZ_4K = 2'd0, SZ_2M = 2'd1, SZ_1G = 2'd2} pg_size_e;
    typedef enum logic [1:0] {FLT_NONE = 2'd0, FLT_ABSENT = 2'd1, FLT_RSVD = 2'd2} flt_e;
    typedef enum logic [1:0] {ACC_LOAD = 2'd0, ACC_STORE = 2'd1, ACC_FETCH = 2'd2} acc_e;
    typedef enum logic [2:0] {ST_IDLE, ST_RD, ST_RWAIT, ST_CHECK, ST_CAS, ST_CWAIT} st_e;

    typedef struct packed {
        logic exec;
        logic user;
        logic write;
    } perm_t;

    typedef struct packed {
        logic     present;
        logic     rsvd;
        logic     leaf;
        pg_size_e size;
    } ent_cls_t;

    function automatic logic [IDX_W-1:0] va_index(logic [63:0] va, logic [LVL_W-1:0] lvl);
        logic [63:0] s;
        s = va >> (PG_SH + IDX_W * int'(lvl));
        return s[IDX_W-1:0];
    endfunction
endpackage

// File: rtl/pw_entry_check.sv
module pw_entry_check
    import pw_pkg::*;
#(
    parameter int PHYS_BITS = 52
) (
    input  logic [63:0]      entry,
    input  logic [LVL_W-1:0] lvl,
    input  logic             nxe,
    output ent_cls_t         cls
);
    localparam logic [63:0] HI_MASK = ADDR_MASK & ~((64'd1 << PHYS_BITS) - 64'd1);

    logic        ps;
    logic [63:0] mask;

    always_comb begin
        ps   = entry[B_PS];
        mask = HI_MASK;
        if (!nxe)
            mask[B_NX] = 1'b1;
        cls.size = SZ_4K;
        cls.leaf = (lvl == '0);
        if (lvl >= LVL_W'(3)) begin
            mask[B_PS] = 1'b1;
        end else if (ps && lvl == LVL_W'(2)) begin
            cls.leaf = 1'b1;
            cls.size = SZ_1G;
            mask     = mask | (LOW_1G & ADDR_MASK & ~PAT_BIT);
        end else if (ps && lvl == LVL_W'(1)) begin
            cls.leaf = 1'b1;
            cls.size = SZ_2M;
            mask     = mask | (LOW_2M & ADDR_MASK & ~PAT_BIT);
        end
        cls.present = entry[B_P];
        cls.rsvd    = |(entry & mask);
    end
endmodule

// File: rtl/pw_addr_gen.sv
module pw_addr_gen
    import pw_pkg::*;
(
    input  logic [63:0]      base,
    input  logic [63:0]      vaddr,
    input  logic [LVL_W-1:0] lvl,
    input  logic [63:0]      entry,
    input  pg_size_e         size,
    output logic [63:0]      ent_addr,
    output logic [63:0]      paddr
);
    logic [63:0] field;

    always_comb begin
        ent_addr = base + (64'(va_index(vaddr, lvl)) << 3);
        field    = entry & ADDR_MASK;
        case (size)
            SZ_2M:   paddr = (field & ~LOW_2M) | (vaddr & LOW_2M);
            SZ_1G:   paddr = (field & ~LOW_1G) | (vaddr & LOW_1G);
            default: paddr = field | (vaddr & 64'h0FFF);
        endcase
    end
endmodule

// File: rtl/pw_walker.sv
module pw_walker
    import pw_pkg::*;
#(
    parameter int PHYS_BITS = 52
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [63:0] req_vaddr,
    input  logic [63:0] req_root,
    input  logic        req_five,
    input  logic        req_nxe,
    input  logic [1:0]  req_acc,
    output logic        rd_valid,
    input  logic        rd_ready,
    output logic [63:0] rd_addr,
    input  logic        rsp_valid,
    input  logic [63:0] rsp_data,
    output logic        cas_valid,
    input  logic        cas_ready,
    output logic [63:0] cas_addr,
    output logic [31:0] cas_old,
    output logic [31:0] cas_new,
    input  logic        cas_done,
    input  logic        cas_ok,
    output logic        done,
    output logic [63:0] done_paddr,
    output logic [1:0]  done_size,
    output logic [1:0]  done_fault,
    output logic [2:0]  done_perm
);
    st_e              st, st_n;
    logic [LVL_W-1:0] lvl_q, top_lvl;
    logic [63:0]      va_q, root_q, base_q, entry_q;
    logic             five_q, nxe_q;
    acc_e             acc_q;
    perm_t            perm_q, ent_perm, perm_fin;
    ent_cls_t         cls;
    logic [63:0]      ent_addr, leaf_pa;
    logic [31:0]      set_bits;
    logic             need_cas, fin_ok, descend, restart;
    flt_e             fin_flt;

    pw_entry_check #(.PHYS_BITS(PHYS_BITS)) u_chk_ent (
        .entry(entry_q), .lvl(lvl_q), .nxe(nxe_q), .cls(cls)
    );

    pw_addr_gen u_agen (
        .base(base_q), .vaddr(va_q), .lvl(lvl_q), .entry(entry_q),
        .size(cls.size), .ent_addr(ent_addr), .paddr(leaf_pa)
    );

    always_comb begin
        top_lvl        = five_q ? LVL_W'(4) : LVL_W'(3);
        ent_perm.exec  = ~entry_q[B_NX];
        ent_perm.user  = entry_q[B_US];
        ent_perm.write = entry_q[B_RW];
        perm_fin       = perm_q & ent_perm;
        if (acc_q != ACC_STORE && !entry_q[B_D])
            perm_fin.write = 1'b0;
        set_bits = 32'd1 << B_A;
        if (cls.leaf && acc_q == ACC_STORE)
            set_bits = set_bits | (32'd1 << B_D);
        need_cas = |(set_bits & ~entry_q[31:0]);
    end

    always_comb begin
        st_n    = st;
        fin_ok  = 1'b0;
        fin_flt = FLT_NONE;
        descend = 1'b0;
        restart = 1'b0;
        case (st)
            ST_IDLE:  if (req_valid) st_n = ST_RD;
            ST_RD:    if (rd_ready) st_n = ST_RWAIT;
            ST_RWAIT: if (rsp_valid) st_n = ST_CHECK;
            ST_CHECK: begin
                if (!cls.present)   fin_flt = FLT_ABSENT;
                else if (cls.rsvd)  fin_flt = FLT_RSVD;
                else if (need_cas)  st_n = ST_CAS;
                else if (cls.leaf)  fin_ok = 1'b1;
                else                descend = 1'b1;
            end
            ST_CAS:   if (cas_ready) st_n = ST_CWAIT;
            ST_CWAIT: begin
                if (cas_done) begin
                    if (cas_ok) begin
                        if (cls.leaf) fin_ok = 1'b1;
                        else          descend = 1'b1;
                    end else if (cls.leaf) begin
                        restart = 1'b1;
                    end else begin
                        st_n = ST_RD;
                    end
                end
            end
            default:  st_n = ST_IDLE;
        endcase
        if (descend || restart)
            st_n = ST_RD;
        if (fin_ok || fin_flt != FLT_NONE)
            st_n = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            lvl_q      <= '0;
            va_q       <= '0;
            root_q     <= '0;
            base_q     <= '0;
            entry_q    <= '0;
            five_q     <= 1'b0;
            nxe_q      <= 1'b0;
            acc_q      <= ACC_LOAD;
            perm_q     <= '0;
            done       <= 1'b0;
            done_paddr <= '0;
            done_size  <= '0;
            done_fault <= '0;
            done_perm  <= '0;
        end else begin
            st   <= st_n;
            done <= 1'b0;
            if (st == ST_IDLE && req_valid) begin
                va_q   <= req_vaddr;
                root_q <= req_root & ADDR_MASK;
                base_q <= req_root & ADDR_MASK;
                five_q <= req_five;
                nxe_q  <= req_nxe;
                acc_q  <= acc_e'(req_acc);
                lvl_q  <= req_five ? LVL_W'(4) : LVL_W'(3);
                perm_q <= '1;
            end
            if (st == ST_RWAIT && rsp_valid)
                entry_q <= rsp_data;
            if (descend) begin
                base_q <= entry_q & ADDR_MASK;
                perm_q <= perm_q & ent_perm;
                lvl_q  <= lvl_q - LVL_W'(1);
            end
            if (restart) begin
                base_q <= root_q;
                perm_q <= '1;
                lvl_q  <= top_lvl;
            end
            if (fin_ok) begin
                done       <= 1'b1;
                done_paddr <= leaf_pa;
                done_size  <= cls.size;
                done_fault <= FLT_NONE;
                done_perm  <= perm_fin;
            end else if (fin_flt != FLT_NONE) begin
                done       <= 1'b1;
                done_paddr <= '0;
                done_size  <= SZ_4K;
                done_fault <= fin_flt;
                done_perm  <= '0;
            end
        end
    end

    assign req_ready = (st == ST_IDLE);
    assign rd_valid  = (st == ST_RD);
    assign rd_addr   = ent_addr;
    assign cas_valid = (st == ST_CAS);
    assign cas_addr  = ent_addr;
    assign cas_old   = entry_q[31:0];
    assign cas_new   = entry_q[31:0] | set_bits;
endmodule

// File: rtl/pw_walker_chk.sv
module pw_walker_chk (
    input logic        clk,
    input logic        rst,
    input logic        rd_valid,
    input logic        rd_ready,
    input logic [63:0] rd_addr,
    input logic        cas_valid,
    input logic [31:0] cas_old,
    input logic [31:0] cas_new,
    input logic        done,
    input logic [63:0] done_paddr,
    input logic [1:0]  done_fault,
    input logic [2:0]  done_perm
);
    a_r1_rd_aligned: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> rd_addr[2:0] == 3'b000);

    a_r13_rd_hold: assert property (@(posedge clk) disable iff (rst)
        rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));

    a_r13_one_port: assert property (@(posedge clk) disable iff (rst)
        !(rd_valid && cas_valid));

    a_r8_cas_only_sets: assert property (@(posedge clk) disable iff (rst)
        cas_valid |-> ((cas_new & cas_old) == cas_old) && (cas_new != cas_old));

    a_r13_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r13_fault_clears: assert property (@(posedge clk) disable iff (rst)
        done && done_fault != 2'd0 |-> done_paddr == 64'd0 && done_perm == 3'd0);

    a_r3_fault_code_legal: assert property (@(posedge clk) disable iff (rst)
        done |-> done_fault != 2'd3);
endmodule

bind pw_walker pw_walker_chk u_walker_chk (
    .clk(clk), .rst(rst), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_addr(rd_addr), .cas_valid(cas_valid), .cas_old(cas_old),
    .cas_new(cas_new), .done(done), .done_paddr(done_paddr),
    .done_fault(done_fault), .done_perm(done_perm)
);

// File: tb/sim_pw_walker.sv
`timescale 1ns/1ps
module sim_pw_walker;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_vaddr = '0;
    logic [63:0] req_root = '0;
    logic        req_five = 1'b0;
    logic        req_nxe = 1'b0;
    logic [1:0]  req_acc = 2'd0;
    logic        rd_valid;
    logic        rd_ready = 1'b1;
    logic [63:0] rd_addr;
    logic        rsp_valid = 1'b0;
    logic [63:0] rsp_data = '0;
    logic        cas_valid;
    logic        cas_ready = 1'b1;
    logic [63:0] cas_addr;
    logic [31:0] cas_old, cas_new;
    logic        cas_done = 1'b0;
    logic        cas_ok = 1'b0;
    logic        done;
    logic [63:0] done_paddr;
    logic [1:0]  done_size, done_fault;
    logic [2:0]  done_perm;

    logic [63:0] mem [logic [63:0]];
    int rd_cnt, cas_cnt, fail_left;
    int total = 0;
    int bad = 0;
    logic [63:0] r_paddr;
    logic [1:0]  r_size, r_fault;
    logic [2:0]  r_perm;

    localparam logic [63:0] ROOT  = 64'h0000_0000_0010_0000;
    localparam logic [63:0] PA4K  = 64'h0000_00AB_CDE0_0000;
    localparam logic [63:0] PA1G  = 64'h0000_00C0_0000_0000;
    localparam logic [63:0] VA4   = 64'h0000_1234_5678_9ABC;
    localparam logic [63:0] VA5   = 64'h00AB_CDEF_1234_5678;
    localparam logic [63:0] NL    = 64'h27;
    localparam logic [63:0] LF    = 64'h67;

    always #4 clk = ~clk;

    pw_walker #(.PHYS_BITS(40)) u0 (.*);

    always @(posedge clk) begin
        rsp_valid <= 1'b0;
        cas_done  <= 1'b0;
        if (!rst && rd_valid && rd_ready) begin
            rsp_valid <= 1'b1;
            rsp_data  <= mem.exists(rd_addr) ? mem[rd_addr] : 64'd0;
            rd_cnt    <= rd_cnt + 1;
        end
        if (!rst && cas_valid && cas_ready) begin
            cas_done <= 1'b1;
            cas_cnt  <= cas_cnt + 1;
            if (fail_left > 0) begin
                fail_left <= fail_left - 1;
                cas_ok    <= 1'b0;
            end else if (mem.exists(cas_addr) && mem[cas_addr][31:0] == cas_old) begin
                mem[cas_addr] = {mem[cas_addr][63:32], cas_new};
                cas_ok <= 1'b1;
            end else begin
                cas_ok <= 1'b0;
            end
        end
    end

    function automatic logic [63:0] idx(logic [63:0] va, int l);
        return (va >> (12 + 9 * l)) & 64'h1FF;
    endfunction

    function automatic logic [63:0] eaddr(logic [63:0] va, int top, int l);
        return ROOT + 64'(top - l) * 64'h1000 + idx(va, l) * 8;
    endfunction

    task automatic ck(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic build(input logic [63:0] va, input int top, input int leaf,
                         input logic [63:0] pa, input logic [63:0] nlf, input logic [63:0] lff);
        logic [63:0] base;
        mem.delete();
        base = ROOT;
        for (int l = top; l >= leaf; l--) begin
            if (l == leaf)
                mem[base + idx(va, l) * 8] = pa | lff;
            else
                mem[base + idx(va, l) * 8] = (base + 64'h1000) | nlf;
            base = base + 64'h1000;
        end
    endtask

    task automatic walk(input logic [63:0] va, input logic five, input logic nxe, input logic [1:0] acc);
        int n;
        rd_cnt = 0;
        cas_cnt = 0;
        @(negedge clk);
        req_vaddr = va; req_root = ROOT; req_five = five; req_nxe = nxe; req_acc = acc;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!done && n < 400) begin
            @(negedge clk);
            n++;
        end
        ck("R13 done seen", 64'(done), 64'd1);
        r_paddr = done_paddr; r_size = done_size; r_fault = done_fault; r_perm = done_perm;
        @(negedge clk);
        ck("R13 done is one pulse", 64'(done), 64'd0);
    endtask

    task automatic t_reset;
        ck("R13 reset done low", 64'(done), 64'd0);
        ck("R13 reset ready", 64'(req_ready), 64'd1);
        ck("R13 reset no read", 64'(rd_valid), 64'd0);
        ck("R13 reset no swap", 64'(cas_valid), 64'd0);
    endtask

    task automatic t_four_4k;
        build(VA4, 3, 0, PA4K, NL, LF);
        walk(VA4, 1'b0, 1'b1, 2'd0);
        ck("R2 four-level reads", 64'(rd_cnt), 64'd4);
        ck("R11 paddr 4K", r_paddr, PA4K | 64'hABC);
        ck("R5 size 4K", 64'(r_size), 64'd0);
        ck("R12 perm full", 64'(r_perm), 64'd7);
        ck("R9 no swap when set", 64'(cas_cnt), 64'd0);
    endtask

    task automatic t_five_4k;
        build(VA5, 4, 0, PA4K, NL, LF);
        walk(VA5, 1'b1, 1'b1, 2'd0);
        ck("R2 five-level reads", 64'(rd_cnt), 64'd5);
        ck("R1 five-level paddr", r_paddr, PA4K | 64'h678);
        ck("R1 five-level fault", 64'(r_fault), 64'd0);
    endtask

    task automatic t_large;
        build(VA4, 3, 1, PA4K, NL, LF | 64'h80);
        walk(VA4, 1'b0, 1'b1, 2'd0);
        ck("R5 2M reads", 64'(rd_cnt), 64'd3);
        ck("R5 2M size", 64'(r_size), 64'd1);
        ck("R11 2M paddr", r_paddr, PA4K | (VA4 & 64'h1F_FFFF));
        build(VA4, 3, 2, PA1G, NL, LF | 64'h80);
        walk(VA4, 1'b0, 1'b1, 2'd0);
        ck("R5 1G reads", 64'(rd_cnt), 64'd2);
        ck("R5 1G size", 64'(r_size), 64'd2);
        ck("R11 1G paddr", r_paddr, PA1G | (VA4 & 64'h3FFF_FFFF));
    endtask

    task automatic t_absent;
        build(VA4, 3, 0, PA4K, NL, LF);
        mem[eaddr(VA4, 3, 2)] = 64'd0;
        walk(VA4, 1'b0, 1'b1, 2'd0);
        ck("R3 absent fault", 64'(r_fault), 64'd1);
        ck("R3 absent stops", 64'(rd_cnt), 64'd2);
        ck("R13 fault paddr zero", r_paddr, 64'd0);
    endtask

    task automatic t_ps_upper;
        build(VA4, 3, 0, PA4K, NL, LF);
        mem[eaddr(VA4, 3, 3)] = mem[eaddr(VA4, 3, 3)] | 64'h80;
        walk(VA4, 1'b0, 1'b1, 2'd0);
        ck("R4 level-4 PS fault", 64'(r_fault), 64'd2);
        ck("R4 level-4 PS reads", 64'(rd_cnt), 64'd1);
        build(VA5, 4, 0, PA4K, NL, LF);
        mem[eaddr(VA5, 4, 4)] = mem[eaddr(VA5, 4, 4)] | 64'h80;
        walk(VA5, 1'b1, 1'b1, 2'd0);
        ck("R4 level-5 PS fault", 64'(r_fault), 64'd2);
    endtask

    task automatic t_rsvd;
        build(VA4, 3, 0, PA4K, NL, LF);
        mem[eaddr(VA4, 3, 2)] = mem[eaddr(VA4, 3, 2)] | (64'd1 << 45);
        walk(VA4, 1'b0, 1'b1, 2'd0);
        ck("R6 high phys bit fault", 64'(r_fault), 64'd2);
        ck("R6 high phys bit reads", 64'(rd_cnt), 64'd2);
        build(VA4, 3, 0, PA4K, NL, LF | (64'd1 << 63));
        walk(VA4, 1'b0, 1'b0, 2'd0);
        ck("R6 NX with nxe off", 64'(r_fault), 64'd2);
        walk(VA4, 1'b0, 1'b1, 2'd0);
        ck("R6 NX with nxe on ok", 64'(r_fault), 64'd0);
        ck("R12 NX clears exec", 64'(r_perm), 64'd3);
    endtask

    task automatic t_leaf_low;
        build(VA4, 3, 1, PA4K, NL, LF | 64'h80 | 64'h2000);
        walk(VA4, 1'b0, 1'b1, 2'd0);
        ck("R7 2M bit13 fault", 64'(r_fault), 64'd2);
        build(VA4, 3, 1, PA4K, NL, LF | 64'h80 | 64'h1000);
        walk(VA4, 1'b0, 1'b1, 2'd0);
        ck("R7 2M bit12 allowed", 64'(r_fault), 64'd0);
        ck("R7 2M bit12 paddr", r_paddr, PA4K | (VA4 & 64'h1F_FFFF));
        build(VA4, 3, 2, PA1G, NL, LF | 64'h80 | 64'h2000_0000);
        walk(VA4, 1'b0, 1'b1, 2'd0);
        ck("R7 1G bit29 fault", 64'(r_fault), 64'd2);
    endtask

    task automatic t_accessed;
        build(VA4, 3, 0, PA4K, 64'h07, LF);
        walk(VA4, 1'b0, 1'b1, 2'd0);
        ck("R8 swaps on tables", 64'(cas_cnt), 64'd3);
        ck("R8 accessed now set", mem[eaddr(VA4, 3, 3)] & 64'h20, 64'h20);
        ck("R8 walk ok", r_paddr, PA4K | 64'hABC);
        build(VA4, 3, 0, PA4K, NL, 64'h07);
        walk(VA4, 1'b0, 1'b1, 2'd1);
        ck("R9 store swap count", 64'(cas_cnt), 64'd1);
        ck("R9 store sets A and D", mem[eaddr(VA4, 3, 0)] & 64'h60, 64'h60);
        ck("R10 store keeps write", 64'(r_perm), 64'd7);
    endtask

    task automatic t_clean_load;
        build(VA4, 3, 0, PA4K, NL, 64'h27);
        walk(VA4, 1'b0, 1'b1, 2'd0);
        ck("R10 clean load no write", 64'(r_perm), 64'd6);
        ck("R9 load no swap", 64'(cas_cnt), 64'd0);
        ck("R9 load leaves D clear", mem[eaddr(VA4, 3, 0)] & 64'h40, 64'h0);
        walk(VA4, 1'b0, 1'b1, 2'd2);
        ck("R10 clean fetch no write", 64'(r_perm), 64'd6);
    endtask

    task automatic t_retry;
        build(VA4, 3, 0, PA4K, 64'h07, LF);
        fail_left = 1;
        walk(VA4, 1'b0, 1'b1, 2'd0);
        ck("R8 table retry reads", 64'(rd_cnt), 64'd5);
        ck("R8 table retry swaps", 64'(cas_cnt), 64'd4);
        ck("R8 table retry result", r_paddr, PA4K | 64'hABC);
        build(VA4, 3, 0, PA4K, NL, 64'h27);
        fail_left = 1;
        walk(VA4, 1'b0, 1'b1, 2'd1);
        ck("R9 leaf restart reads", 64'(rd_cnt), 64'd8);
        ck("R9 leaf restart swaps", 64'(cas_cnt), 64'd2);
        ck("R9 leaf restart fault", 64'(r_fault), 64'd0);
    endtask

    task automatic t_perm;
        build(VA4, 3, 0, PA4K, NL, LF);
        mem[eaddr(VA4, 3, 2)] = mem[eaddr(VA4, 3, 2)] & ~64'h4;
        walk(VA4, 1'b0, 1'b1, 2'd2);
        ck("R12 user cleared mid-level", 64'(r_perm), 64'd5);
        mem[eaddr(VA4, 3, 1)] = mem[eaddr(VA4, 3, 1)] & ~64'h2;
        walk(VA4, 1'b0, 1'b1, 2'd0);
        ck("R12 write cleared", 64'(r_perm), 64'd4);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL R13 watchdog expired actual=hung expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rd_cnt = 0; cas_cnt = 0; fail_left = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_four_4k();
        t_five_4k();
        t_large();
        t_absent();
        t_ps_upper();
        t_rsvd();
        t_leaf_low();
        t_accessed();
        t_clean_load();
        t_retry();
        t_perm();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule